// File: doc/BRIEF.md
# Pulse-Timestamped Oscillator Frequency Error Meter

This block measures how far a local reference oscillator is from its nominal frequency, using an external once-per-second timing pulse as the yardstick. A counter clocked by the oscillator runs without ever being cleared. On each rising edge of the pulse input, after that input has been synchronized into the oscillator's clock domain, the counter value is latched. The previous latched value is subtracted from it with wrap-around arithmetic, giving the number of oscillator cycles in the last second. The expected cycle count for one second, supplied as an input, is then subtracted to form a signed error: zero when the oscillator is exactly on frequency, negative when it is slow, positive when it is fast.

A single one-second error is coarse, because the capture is quantised to one clock and the pulse itself jitters. The block can therefore sum the per-second errors over a programmable number of seconds and report only the sum, once per window, with a one-cycle valid strobe. Loop filtering and the oscillator control voltage are handled downstream.

The control is a two-state machine. `ST_SEED` is entered at reset; the first synchronized rising edge only loads the capture register and moves the machine to `ST_RUN` (transition *seed*). In `ST_RUN` every later rising edge either adds its error to the running sum (transition *accumulate*) or, when the window length is reached, publishes the sum, pulses valid and clears the sum (transition *close*); the machine stays in `ST_RUN` until reset.

Top module: `pps_freq_err_counter`

## Requirements
- R1: While reset is asserted and after its release, before any pulse, `err_sum`, `err_valid` and `raw_cap` are all zero.
- R2: A capture happens only on a rising edge of `pps_in`; a falling edge or a long high level leaves `raw_cap` unchanged.
- R3: The first rising edge after reset loads `raw_cap` but produces no `err_valid` pulse.
- R4: The per-second error is (current capture minus previous capture, modulo 2^CNT_W) minus `nominal_cnt`, reported in two's complement on `err_sum`; an interval equal to the nominal gives zero, shorter gives negative, longer gives positive.
- R5: The counter is never cleared by the pulse, so two consecutive `raw_cap` values differ, modulo 2^CNT_W, by exactly the number of clock cycles between the two rising edges.
- R6: When the counter wraps between two captures, the interval and error are still correct (shown with an 8-bit counter).
- R7: With a window length N, `err_valid` pulses after every N-th measured second with `err_sum` equal to the sum of those N errors; no pulse appears on the other seconds, and the next window starts from zero.
- R8: `err_valid` is high for exactly one clock cycle per report.
- R9: A window length of 0 on `avg_secs` behaves as a length of 1.
- R10: The window length is read at each measured second; if it has been lowered below the number of seconds already summed, the window closes at the next measured second with all seconds summed so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference oscillator clock; drives the free-running counter |
| rst | input | 1 | Asynchronous active-high reset |
| pps_in | input | 1 | Asynchronous once-per-second timing pulse |
| nominal_cnt | input | CNT_W (32) | Expected oscillator cycles per second |
| avg_secs | input | AVG_W (16) | Number of seconds summed per report (0 acts as 1) |
| err_sum | output | CNT_W+AVG_W+1 (49) | Signed sum of per-second errors over the last window |
| err_valid | output | 1 | One-cycle strobe when a new `err_sum` is published |
| raw_cap | output | CNT_W (32) | Counter value latched at the most recent rising edge |

## Verification
The hardest condition to reach from the ports is a counter wrap between two captures, since a 32-bit counter takes billions of cycles to roll over; the bench adds a second instance with an 8-bit counter and spaces its pulses 200 to 250 cycles apart so nearly every interval straddles a wrap. A second awkward case is a window length lowered in the middle of a window, reached by writing `avg_secs` between two pulses after some seconds have already been summed. Interval lengths and pulse widths are drawn at random around the nominal count, so errors of both signs and long high levels of the pulse occur in the same run.

// File: rtl/pps_fec_pkg.sv
package pps_fec_pkg;

    typedef enum logic [0:0] {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } fec_state_e;

endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pps_free_counter.sv
module pps_free_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + W'(1);
    end

    assign count = cnt_q;

    // R5
    free_run_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/pps_interval.sv
module pps_interval #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  prev,
    input  logic [CNT_W-1:0]  nominal,
    output logic signed [CNT_W:0] err_sec
);

    logic [CNT_W-1:0] span;

    always_comb begin
        span    = count - prev;
        err_sec = $signed({1'b0, span}) - $signed({1'b0, nominal});
    end

endmodule

// File: rtl/pps_err_accum.sv
module pps_err_accum
    import pps_fec_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int AVG_W = 16,
    localparam int ACC_W = CNT_W + AVG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rise,
    input  logic [CNT_W-1:0]        count,
    input  logic signed [CNT_W:0]   err_sec,
    input  logic [AVG_W-1:0]        avg_len,
    output logic [CNT_W-1:0]        cap_out,
    output logic signed [ACC_W-1:0] sum_out,
    output logic                    valid_out
);

    fec_state_e state_q, state_d;

    logic [CNT_W-1:0]        cap_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] err_q;
    logic [AVG_W-1:0]        sec_q;
    logic                    valid_q;

    logic [AVG_W:0]          len_eff;
    logic [AVG_W:0]          sec_next;
    logic signed [ACC_W-1:0] acc_sum;
    logic                    close;

    always_comb begin
        len_eff  = (avg_len == '0) ? (AVG_W+1)'(1) : {1'b0, avg_len};
        sec_next = {1'b0, sec_q} + (AVG_W+1)'(1);
        acc_sum  = acc_q + ACC_W'(err_sec);
        close    = (sec_next >= len_eff);
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ST_SEED;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED: if (rise) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cap_q   <= '0;
            acc_q   <= '0;
            err_q   <= '0;
            sec_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (rise) begin
                cap_q <= count;
                unique case (state_q)
                    ST_SEED: begin
                        acc_q <= '0;
                        sec_q <= '0;
                    end
                    ST_RUN: begin
                        if (close) begin
                            err_q   <= acc_sum;
                            valid_q <= 1'b1;
                            acc_q   <= '0;
                            sec_q   <= '0;
                        end else begin
                            acc_q <= acc_sum;
                            sec_q <= sec_next[AVG_W-1:0];
                        end
                    end
                endcase
            end
        end
    end

    assign cap_out   = cap_q;
    assign sum_out   = err_q;
    assign valid_out = valid_q;

    // R3
    seed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEED) |=> !valid_q);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R7
    window_clear_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (sec_q == '0 && acc_q == '0));

    // R2
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rise) |-> $stable(cap_q));

endmodule

// File: rtl/pps_freq_err_counter.sv
module pps_freq_err_counter #(
    parameter int CNT_W       = 32,
    parameter int AVG_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int ACC_W      = CNT_W + AVG_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pps_in,
    input  logic [CNT_W-1:0] nominal_cnt,
    input  logic [AVG_W-1:0] avg_secs,
    output logic [ACC_W-1:0] err_sum,
    output logic             err_valid,
    output logic [CNT_W-1:0] raw_cap
);

    logic                  rise;
    logic [CNT_W-1:0]      count;
    logic [CNT_W-1:0]      cap;
    logic signed [CNT_W:0] err_sec;
    logic signed [ACC_W-1:0] sum;

    pps_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pps_in),
        .rise     (rise)
    );

    pps_free_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    pps_interval #(.CNT_W(CNT_W)) u_ival (
        .count   (count),
        .prev    (cap),
        .nominal (nominal_cnt),
        .err_sec (err_sec)
    );

    pps_err_accum #(.CNT_W(CNT_W), .AVG_W(AVG_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .count     (count),
        .err_sec   (err_sec),
        .avg_len   (avg_secs),
        .cap_out   (cap),
        .sum_out   (sum),
        .valid_out (err_valid)
    );

    assign err_sum = sum;
    assign raw_cap = cap;

endmodule

// File: tb/pps_freq_err_counter_bench.sv
module pps_freq_err_counter_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        pps_m = 1'b0, pps_n = 1'b0;
    logic [31:0] nom_m = '0;
    logic [7:0]  nom_n = '0;
    logic [15:0] avg_m = '0, avg_n = '0;
    logic [48:0] err_m;
    logic [24:0] err_n;
    logic        val_m, val_n;
    logic [31:0] raw_m;
    logic [7:0]  raw_n;

    pps_freq_err_counter u_pps_freq_err_counter (
        .clk(clk), .rst(rst), .pps_in(pps_m), .nominal_cnt(nom_m),
        .avg_secs(avg_m), .err_sum(err_m), .err_valid(val_m), .raw_cap(raw_m));

    pps_freq_err_counter #(.CNT_W(8)) u_pps_freq_err_counter_narrow (
        .clk(clk), .rst(rst), .pps_in(pps_n), .nominal_cnt(nom_n),
        .avg_secs(avg_n), .err_sum(err_n), .err_valid(val_n), .raw_cap(raw_n));

    int checks = 0, fails = 0;
    bit done = 1'b0;

    int     vcnt [2] = '{0, 0};
    int     dbl  [2] = '{0, 0};
    longint vlast[2] = '{0, 0};
    bit     vprev[2] = '{0, 0};

    always @(negedge clk) begin
        if (val_m) begin vcnt[0]++; vlast[0] = longint'($signed(err_m)); if (vprev[0]) dbl[0]++; end
        if (val_n) begin vcnt[1]++; vlast[1] = longint'($signed(err_n)); if (vprev[1]) dbl[1]++; end
        vprev[0] = val_m;
        vprev[1] = val_n;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bench-side model state per instance
    bit     seeded [2] = '{0, 0};
    int     last_iv[2] = '{0, 0};
    longint raw_prv[2] = '{0, 0};
    longint exp_acc[2] = '{0, 0};
    int     win    [2] = '{0, 0};

    function automatic longint rawv(input int k);
        return (k == 0) ? longint'(raw_m) : longint'(raw_n);
    endfunction

    function automatic longint maskv(input int k);
        return (k == 0) ? 64'hFFFF_FFFF : 64'hFF;
    endfunction

    function automatic longint nomv(input int k);
        return (k == 0) ? longint'(nom_m) : longint'(nom_n);
    endfunction

    function automatic int lenv(input int k);
        int a;
        a = (k == 0) ? int'(avg_m) : int'(avg_n);
        return (a == 0) ? 1 : a;
    endfunction

    // one pulse: rise, hold high for hi cycles, low for the rest of iv cycles
    task automatic send(input int k, input int iv, input int hi, input string tag);
        longint r_hi, r_lo, d, e;
        int v0;
        v0 = vcnt[k];
        @(negedge clk);
        if (k == 0) pps_m = 1'b1; else pps_n = 1'b1;
        repeat (hi) @(negedge clk);
        r_hi = rawv(k);
        if (k == 0) pps_m = 1'b0; else pps_n = 1'b0;
        repeat (iv - hi - 1) @(negedge clk);
        r_lo = rawv(k);
        // R2: falling edge and low level leave the capture alone
        chk(r_lo == r_hi, "R2 capture held after falling edge", r_lo, r_hi);
        if (!seeded[k]) begin
            chk(vcnt[k] == v0, "R3 no report on seed pulse", vcnt[k], v0);
            seeded[k] = 1'b1;
        end else begin
            d = (r_lo - raw_prv[k]) & maskv(k);
            chk(d == (longint'(last_iv[k]) & maskv(k)),
                (k == 0) ? "R5 capture spacing" : "R6 capture spacing across wrap",
                d, longint'(last_iv[k]));
            e = longint'(last_iv[k]) - nomv(k);
            exp_acc[k] += e;
            win[k]++;
            if (win[k] >= lenv(k)) begin
                chk(vcnt[k] == v0 + 1, {tag, " report count"}, vcnt[k], v0 + 1);
                chk(vlast[k] == exp_acc[k], {tag, " error value"}, vlast[k], exp_acc[k]);
                exp_acc[k] = 0;
                win[k] = 0;
            end else begin
                chk(vcnt[k] == v0, "R7 no report mid-window", vcnt[k], v0);
            end
        end
        raw_prv[k] = r_lo;
        last_iv[k] = iv;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(err_m == '0, "R1 err_sum in reset", longint'(err_m), 0);
        chk(val_m == 1'b0, "R1 valid in reset", val_m, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(raw_m == '0, "R1 raw_cap after reset", raw_m, 0);
        chk(err_m == '0 && val_m == 1'b0, "R1 outputs after reset", longint'(err_m), 0);

        // per-second errors, both signs and zero
        nom_m = 32'd100;
        avg_m = 16'd1;
        send(0, 100, 8, "R3");
        send(0, 100, 8, "R4 on-frequency");
        send(0, 100, 60, "R4 zero error");
        send(0, 97, 30, "R4 slow");
        send(0, 105, 90, "R4 fast");
        for (int i = 0; i < 8; i++)
            send(0, $urandom_range(80, 120), $urandom_range(6, 70), "R4 random");

        // window of 4 seconds
        avg_m = 16'd4;
        for (int i = 0; i < 12; i++)
            send(0, $urandom_range(85, 115), $urandom_range(6, 70), "R7 window sum");

        // length 0 acts as 1
        avg_m = 16'd0;
        for (int i = 0; i < 3; i++)
            send(0, $urandom_range(90, 110), 10, "R9 zero length");

        // length lowered mid-window
        avg_m = 16'd5;
        send(0, 104, 10, "R10");
        send(0, 93, 10, "R10");
        avg_m = 16'd2;
        send(0, 111, 10, "R10 lowered length");

        // large nominal: strongly negative; zero nominal: raw interval
        nom_m = 32'd5000;
        avg_m = 16'd3;
        for (int i = 0; i < 6; i++)
            send(0, $urandom_range(60, 140), 12, "R4 large nominal");
        nom_m = 32'd0;
        avg_m = 16'd1;
        for (int i = 0; i < 3; i++)
            send(0, $urandom_range(60, 140), 12, "R4 zero nominal");

        // narrow counter: wraps between most captures
        nom_n = 8'd220;
        avg_n = 16'd1;
        send(1, 210, 20, "R3");
        for (int i = 0; i < 6; i++)
            send(1, $urandom_range(200, 250), $urandom_range(6, 150), "R6 wrap");
        avg_n = 16'd3;
        for (int i = 0; i < 9; i++)
            send(1, $urandom_range(200, 250), $urandom_range(6, 150), "R6 wrap window");

        repeat (10) @(negedge clk);
        chk(dbl[0] == 0, "R8 single-cycle valid main", dbl[0], 0);
        chk(dbl[1] == 0, "R8 single-cycle valid narrow", dbl[1], 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule